// File: doc/BRIEF.md
# Oversampled serial frame receiver

This block recovers asynchronous serial characters from a single receive line. The line is examined only on clock cycles where a 16x bit-rate strobe is high. The frame layout comes from a set of line-control inputs: data word length from five to eight bits, an optional parity bit, odd or even parity, and stick parity, where the parity bit is forced to a fixed level.

A character starts with a high-to-low transition on the line. The start bit is confirmed at its centre, then every later bit is sampled at its centre. Data arrives least significant bit first. For each completed frame the block gives a one-cycle valid strobe. Together with it come the received word, right-justified and zero-filled, and three flags: parity error, framing error and break. These outputs keep their values until the next frame completes. Only one stop bit is ever examined. After a break, the receiver stays idle until the line returns high.

The line-control inputs must be held steady while a frame is being received.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `rx_valid`, `rx_data`, `rx_parity_err`, `rx_frame_err` and `rx_break` are all 0.
- R2: `lcr_wlen` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit received goes to `rx_data[0]`. Bits of `rx_data` above the word length read 0.
- R3: A start is confirmed by a sample taken 8 strobes after the strobe that saw the line low. If that sample is high, the start is dropped and no frame is reported.
- R4: Each data, parity and stop bit is sampled 16 strobes after the previous sample.
- R5: When `lcr_par_en` is 1, one parity bit is taken between the last data bit and the stop bit. When it is 0, no parity bit is taken and `rx_parity_err` reads 0.
- R6: With parity on and `lcr_par_stick` = 0, `rx_parity_err` is set when the data bits plus the parity bit hold an even number of ones (`lcr_par_even` = 0) or an odd number (`lcr_par_even` = 1).
- R7: With parity on and `lcr_par_stick` = 1, the parity bit must be 1 when `lcr_par_even` = 0 and must be 0 when `lcr_par_even` = 1. Any other value sets `rx_parity_err`.
- R8: Only the first stop bit is sampled. A 0 there sets `rx_frame_err`. A new start bit may follow a single stop bit directly.
- R9: When the start, data, parity (if enabled) and stop samples are all 0, `rx_break` is set. No further frame is started until the line has been seen high.
- R10: `rx_valid` is high for exactly one clock per completed frame. `rx_data` and the flags change only together with `rx_valid`.
- R11: A start is taken only from a low sample that follows a high sample. A line that is low from reset onward starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | Strobe at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| lcr_wlen | input | 2 | Data word length code (5 + code bits) |
| lcr_par_en | input | 1 | Parity bit present |
| lcr_par_even | input | 1 | Even parity; with stick set, expect 0 |
| lcr_par_stick | input | 1 | Stick parity select |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| rx_data | output | 8 | Received word, zero-extended |
| rx_parity_err | output | 1 | Parity mismatch in the last frame |
| rx_frame_err | output | 1 | First stop bit was 0 in the last frame |
| rx_break | output | 1 | Whole frame was 0 in the last frame |

## Verification
Parity error and framing error are both decided at the stop-bit sample, so both can be raised on the same valid strobe. Break adds a third flag on that same strobe. The bench provokes the overlap with frames that carry a deliberately wrong parity bit and a low stop bit, and with all-zero frames held low across the parity and stop positions. A behavioural model counts strobes since the start edge and predicts all three flags. It is compared with the design on every clock, and directed checks also confirm the captured flag combination.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic at_half,
    output logic at_full
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            if (restart || cnt_q == FULL_LAST) cnt_d = '0;
            else                               cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_half = tick && (cnt_q == HALF_LAST);
    assign at_full = tick && (cnt_q == FULL_LAST);
endmodule

// File: rtl/uart_rx_parity_chk.sv
module uart_rx_parity_chk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic              par_bit,
    input  logic              even_sel,
    input  logic              stick_sel,
    output logic              mismatch
);
    logic ones_odd;
    logic want;

    always_comb begin
        ones_odd = ^word;
        if (stick_sel) want = ~even_sel;
        else           want = even_sel ? ones_odd : ~ones_odd;
        mismatch = (par_bit != want);
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_frame_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              rxd,
    input  logic [1:0]        lcr_wlen,
    input  logic              lcr_par_en,
    input  logic              lcr_par_even,
    input  logic              lcr_par_stick,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              rx_break
);
    localparam int MIN_W = DATA_W - 3;
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              allz;
        logic              pbit;
        logic              last;
        logic              valid;
        logic [DATA_W-1:0] dout;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_regs_t;

    rx_regs_t         r_d, r_q;
    logic             restart;
    logic             at_half, at_full;
    logic             par_bad;
    logic [IDX_W-1:0] last_idx;

    uart_rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_16x),
        .restart (restart),
        .at_half (at_half),
        .at_full (at_full)
    );

    uart_rx_parity_chk #(.DATA_W(DATA_W)) u_par (
        .word      (r_q.shreg),
        .par_bit   (r_q.pbit),
        .even_sel  (lcr_par_even),
        .stick_sel (lcr_par_stick),
        .mismatch  (par_bad)
    );

    assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(lcr_wlen);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        restart   = 1'b0;
        if (tick_16x) begin
            r_d.last = rxd;
            unique case (r_q.st)
                RX_IDLE: begin
                    if (!rxd && r_q.last) begin
                        r_d.st  = RX_START;
                        restart = 1'b1;
                    end
                end
                RX_START: begin
                    if (at_half) begin
                        restart = 1'b1;
                        if (rxd) begin
                            r_d.st = RX_IDLE;
                        end else begin
                            r_d.st    = RX_DATA;
                            r_d.shreg = '0;
                            r_d.idx   = '0;
                            r_d.allz  = 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_full) begin
                        r_d.shreg[r_q.idx] = rxd;
                        r_d.allz           = r_q.allz & ~rxd;
                        if (r_q.idx == last_idx)
                            r_d.st = lcr_par_en ? RX_PARITY : RX_STOP;
                        else
                            r_d.idx = r_q.idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (at_full) begin
                        r_d.pbit = rxd;
                        r_d.allz = r_q.allz & ~rxd;
                        r_d.st   = RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (at_full) begin
                        r_d.valid = 1'b1;
                        r_d.dout  = r_q.shreg;
                        r_d.perr  = lcr_par_en & par_bad;
                        r_d.ferr  = ~rxd;
                        r_d.brk   = r_q.allz & ~rxd;
                        r_d.st    = (r_q.allz & ~rxd) ? RX_HOLD : RX_IDLE;
                    end
                end
                RX_HOLD: begin
                    if (rxd) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= RX_IDLE;
            r_q.allz  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_valid      = r_q.valid;
    assign rx_data       = r_q.dout;
    assign rx_parity_err = r_q.perr;
    assign rx_frame_err  = r_q.ferr;
    assign rx_break      = r_q.brk;
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_16x,
    input logic [1:0]        lcr_wlen,
    input logic              lcr_par_en,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_parity_err,
    input logic              rx_frame_err,
    input logic              rx_break
);
    localparam int MIN_W = DATA_W - 3;

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data) && $stable(rx_frame_err) && $stable(rx_break));

    a_r4_valid_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick_16x));

    a_r9_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_frame_err && rx_data == '0));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (MIN_W + int'(lcr_wlen))) == '0));

    a_r5_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !lcr_par_en) |-> !rx_parity_err);
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_16x      (tick_16x),
    .lcr_wlen      (lcr_wlen),
    .lcr_par_en    (lcr_par_en),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rx_break      (rx_break)
);

// File: tb/uart_frame_rx_test.sv
module uart_frame_rx_test;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       rxd = 1'b0;
    logic [1:0] lcr_wlen = 2'd3;
    logic       lcr_par_en = 1'b0;
    logic       lcr_par_even = 1'b0;
    logic       lcr_par_stick = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_parity_err, rx_frame_err, rx_break;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    uart_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
        .lcr_wlen(lcr_wlen), .lcr_par_en(lcr_par_en),
        .lcr_par_even(lcr_par_even), .lcr_par_stick(lcr_par_stick),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick_16x = 1'b1;
            @(negedge clk);
            tick_16x = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model: strobe count since the start edge
    int       m_mode = 0;
    int       m_t = 0;
    bit       m_last = 1'b0;
    bit [7:0] m_acc = '0;
    bit       m_allz = 1'b1;
    bit       m_pb = 1'b0;
    bit       e_valid = 1'b0;
    bit [7:0] e_data = '0;
    bit       e_perr = 1'b0, e_ferr = 1'b0, e_brk = 1'b0;

    always @(posedge clk) begin
        e_valid = 1'b0;
        if (!rst_n) begin
            m_mode = 0; m_last = 1'b0; e_data = '0;
            e_perr = 1'b0; e_ferr = 1'b0; e_brk = 1'b0;
        end else if (tick_16x) begin
            int w;
            int k;
            int ones;
            w = 5 + int'(lcr_wlen);
            case (m_mode)
                0: if (!rxd && m_last) begin m_mode = 1; m_t = 0; end
                1: begin
                    m_t++;
                    if (m_t == 8) begin
                        if (rxd) m_mode = 0;
                        else begin m_acc = '0; m_allz = 1'b1; end
                    end else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
                        k = (m_t - 8) / 16;
                        if (k <= w) begin
                            m_acc[k-1] = rxd;
                            if (rxd) m_allz = 1'b0;
                        end else if (lcr_par_en && k == w + 1) begin
                            m_pb = rxd;
                            if (rxd) m_allz = 1'b0;
                        end else begin
                            ones = $countones(m_acc) + int'(m_pb);
                            e_valid = 1'b1;
                            e_data  = m_acc;
                            if (!lcr_par_en)       e_perr = 1'b0;
                            else if (lcr_par_stick) e_perr = (m_pb != !lcr_par_even);
                            else if (lcr_par_even)  e_perr = (ones % 2 != 0);
                            else                    e_perr = (ones % 2 != 1);
                            e_ferr = !rxd;
                            e_brk  = m_allz && !rxd;
                            m_mode = e_brk ? 2 : 0;
                        end
                    end
                end
                default: if (rxd) m_mode = 0;
            endcase
            m_last = rxd;
        end
    end

    int       cap_cnt = 0;
    bit [7:0] cap_data;
    bit       cap_perr, cap_ferr, cap_brk;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " R10 valid vs model"}, int'(rx_valid), int'(e_valid));
            if (e_valid) begin
                chk({cur_req, " data vs model"}, int'(rx_data), int'(e_data));
                chk({cur_req, " perr vs model"}, int'(rx_parity_err), int'(e_perr));
                chk({cur_req, " ferr vs model"}, int'(rx_frame_err), int'(e_ferr));
                chk({cur_req, " brk vs model"}, int'(rx_break), int'(e_brk));
            end
            if (rx_valid) begin
                cap_cnt++;
                cap_data = rx_data; cap_perr = rx_parity_err;
                cap_ferr = rx_frame_err; cap_brk = rx_break;
            end
        end
    end

    task automatic set_cfg(input int w, input bit pen, input bit even, input bit stick);
        lcr_wlen = 2'(w - 5); lcr_par_en = pen; lcr_par_even = even; lcr_par_stick = stick;
    endtask

    function automatic bit good_par(input bit [7:0] d, input int w, input bit even, input bit stick);
        int ones;
        ones = $countones(d & 8'((1 << w) - 1));
        if (stick) return !even;
        return even ? bit'(ones % 2) : !bit'(ones % 2);
    endfunction

    task automatic line(input bit v, input int bits);
        rxd = v;
        repeat (bits * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input bit [7:0] d, input bit pbit, input bit stopv, input int idle_bits);
        int w;
        w = 5 + int'(lcr_wlen);
        line(1'b0, 1);
        for (int i = 0; i < w; i++) line(d[i], 1);
        if (lcr_par_en) line(pbit, 1);
        line(stopv, 1);
        if (idle_bits > 0) line(1'b1, idle_bits);
    endtask

    task automatic frame_expect(input string req, input bit [7:0] d, input bit pbit, input bit stopv,
                                input bit [7:0] xd, input bit xp, input bit xf, input bit xb);
        int n0;
        cur_req = req;
        n0 = cap_cnt;
        send_frame(d, pbit, stopv, 2);
        chk({req, " frame count"}, cap_cnt - n0, 1);
        chk({req, " data"}, int'(cap_data), int'(xd));
        chk({req, " parity flag"}, int'(cap_perr), int'(xp));
        chk({req, " framing flag"}, int'(cap_ferr), int'(xf));
        chk({req, " break flag"}, int'(cap_brk), int'(xb));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n0;
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 valid in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", int'(rx_valid), 0);
        chk("R1 data", int'(rx_data), 0);
        chk("R1 flags", int'({rx_parity_err, rx_frame_err, rx_break}), 0);

        cur_req = "R11";
        n0 = cap_cnt;
        line(1'b0, 3);
        line(1'b1, 2);
        chk("R11 low from reset starts nothing", cap_cnt - n0, 0);

        set_cfg(8, 0, 0, 0);
        frame_expect("R2 R4 8-bit", 8'hA5, 0, 1, 8'hA5, 0, 0, 0);
        set_cfg(5, 0, 0, 0);
        frame_expect("R2 5-bit", 8'hF3, 0, 1, 8'h13, 0, 0, 0);
        set_cfg(6, 0, 0, 0);
        frame_expect("R2 6-bit", 8'h2D, 0, 1, 8'h2D, 0, 0, 0);
        set_cfg(7, 0, 0, 0);
        frame_expect("R2 7-bit", 8'hC1, 0, 1, 8'h41, 0, 0, 0);

        set_cfg(8, 1, 0, 0);
        frame_expect("R5 R6 odd good", 8'h37, good_par(8'h37, 8, 0, 0), 1, 8'h37, 0, 0, 0);
        frame_expect("R6 odd bad", 8'h37, !good_par(8'h37, 8, 0, 0), 1, 8'h37, 1, 0, 0);
        set_cfg(7, 1, 1, 0);
        frame_expect("R6 even good", 8'h55, good_par(8'h55, 7, 1, 0), 1, 8'h55, 0, 0, 0);
        frame_expect("R6 even bad", 8'h55, !good_par(8'h55, 7, 1, 0), 1, 8'h55, 1, 0, 0);

        set_cfg(8, 1, 0, 1);
        frame_expect("R7 mark good", 8'h00, 1, 1, 8'h00, 0, 0, 0);
        frame_expect("R7 mark bad", 8'h01, 0, 1, 8'h01, 1, 0, 0);
        set_cfg(8, 1, 1, 1);
        frame_expect("R7 space good", 8'hFF, 0, 1, 8'hFF, 0, 0, 0);
        frame_expect("R7 space bad", 8'hFE, 1, 1, 8'hFE, 1, 0, 0);

        set_cfg(8, 0, 0, 0);
        frame_expect("R8 stop low", 8'h81, 0, 0, 8'h81, 0, 1, 0);
        cur_req = "R8";
        n0 = cap_cnt;
        send_frame(8'h12, 0, 1, 0);
        send_frame(8'h34, 0, 1, 2);
        chk("R8 back-to-back count", cap_cnt - n0, 2);
        chk("R8 second data", int'(cap_data), 8'h34);

        set_cfg(8, 1, 0, 0);
        frame_expect("R6 R8 parity and framing", 8'h5A, !good_par(8'h5A, 8, 0, 0), 0, 8'h5A, 1, 1, 0);

        cur_req = "R3";
        n0 = cap_cnt;
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        line(1'b1, 2);
        chk("R3 glitch dropped", cap_cnt - n0, 0);

        cur_req = "R9";
        set_cfg(8, 1, 1, 0);
        n0 = cap_cnt;
        line(1'b0, 30);
        line(1'b1, 2);
        chk("R9 one frame for break", cap_cnt - n0, 1);
        chk("R9 break flag", int'(cap_brk), 1);
        chk("R9 framing with break", int'(cap_ferr), 1);
        chk("R9 parity with break", int'(cap_perr), 0);
        frame_expect("R9 recovers", 8'h9C, good_par(8'h9C, 8, 1, 0), 1, 8'h9C, 0, 0, 0);

        for (int i = 0; i < 40; i++) begin
            bit [7:0] d, m;
            int w;
            bit pen, ev, st, flip, stopv, pb;
            d = 8'($urandom); w = 5 + int'($urandom_range(0, 3));
            pen = 1'($urandom); ev = 1'($urandom); st = 1'($urandom);
            flip = ($urandom_range(0, 3) == 0); stopv = ($urandom_range(0, 4) != 0);
            if (i % 8 == 0) d = '0;
            set_cfg(w, pen, ev, st);
            m = d & 8'((1 << w) - 1);
            pb = good_par(d, w, ev, st) ^ flip;
            frame_expect("R2 R5 R6 R7 random", d, pb, stopv, m, pen && flip, !stopv,
                         (m == 0) && (!pen || !pb) && !stopv);
            if ((m == 0) && (!pen || !pb) && !stopv) line(1'b1, 1);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule